// File: doc/BRIEF.md
# Prescaled Binary Up-Counter

A free-running 32-bit up-counter built for high clock rates. A 2-bit low stage advances on every enabled clock. A 30-bit high stage advances only on the single cycle in which the low stage sits at its top value of 3. The long carry chain in the high stage therefore changes state at most once in every four clocks. Static timing can give the high stage's internal register-to-register paths a four-cycle budget. Only the short low stage and the carry decode have to settle within one clock. Both stages share one clock.

The concatenation {high, low} is a plain binary count, because the high stage steps on the same edge on which the low stage wraps from 3 to 0. A count-enable input freezes both stages. A preset input loads any 32-bit value, which lets carry and wrap boundaries be reached quickly. A registered flag marks the all-ones value.

Top module: `prescaled_counter`

## Requirements
- R1: While `cnt_en` is 1 and neither `rst` nor `load_en` is 1, `count` is one greater (modulo 2^32) on the next clock than on the current one.
- R2: `rst` is synchronous and active high, and it takes priority over every other input. One edge with `rst` at 1 leaves `count` at 0 and `term_cnt` at 0.
- R3: The carry into the upper stage fires only when `cnt_en` is 1 and `count[1:0]` is 3. Over any run of enabled cycles, the number of upper-stage steps equals the number of times `count[1:0]` passes from 3 to 0.
- R4: The upper stage `count[31:2]` increments by one on a carry edge and otherwise keeps its value (loads and reset aside). During counting, two of its steps are never closer than four clocks.
- R5: With `cnt_en` at 0 and `load_en` at 0, `count` and `term_cnt` keep their values, including when `count[1:0]` is 3.
- R6: From the value 0xFFFFFFFF, an enabled clock gives 0x00000000.
- R7: `term_cnt` is 1 exactly while `count` equals 0xFFFFFFFF, and it is registered together with `count`.
- R8: With `load_en` at 1 and `rst` at 0, the next edge puts `load_val` into `count`, regardless of `cnt_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both stages |
| rst | input | 1 | Synchronous active-high clear |
| cnt_en | input | 1 | Count enable; 0 freezes the counter |
| load_en | input | 1 | Preset strobe; takes priority over counting |
| load_val | input | 32 | Value written on a preset |
| count | output | 32 | Registered binary count, {upper, lower} |
| term_cnt | output | 1 | High while the count is all ones |

## Verification
The hardest events to reach from the ports are the upper-stage boundaries, such as the step into bit 30, the step into bit 31 and the full wrap from all ones to zero. Counting from zero would need billions of clocks to reach them. The bench therefore presets values a few counts below each boundary and runs through it while it follows a reference integer. It also freezes the counter with the lower stage at 3, so that a carry leaking past the enable gate would show up in the upper bits.

// File: rtl/pscnt_pkg.sv
`timescale 1ns/1ps
package pscnt_pkg;
  // per-cycle action shared by both counter stages
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_STEP  = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } cnt_act_e;
endpackage

// File: rtl/pscnt_ctl.sv
`timescale 1ns/1ps
module pscnt_ctl
  import pscnt_pkg::*;
(
  input  logic     rst,
  input  logic     cnt_en,
  input  logic     load_en,
  input  logic     lo_at_max,
  output cnt_act_e act,
  output logic     hi_step
);
  // priority: clear > load > step > hold
  always_comb begin
    if (rst)          act = ACT_CLEAR;
    else if (load_en) act = ACT_LOAD;
    else if (cnt_en)  act = ACT_STEP;
    else              act = ACT_HOLD;
  end

  // carry into upper stage: one cycle out of every four enabled cycles
  assign hi_step = (act == ACT_STEP) && lo_at_max;
endmodule

// File: rtl/pscnt_low.sv
`timescale 1ns/1ps
module pscnt_low
  import pscnt_pkg::*;
#(
  parameter int LOW_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_act_e         act,
  input  logic [LOW_W-1:0] load_lo,
  output logic [LOW_W-1:0] lo_q,
  output logic             lo_at_max
);
  always_ff @(posedge clk) begin
    case (act)
      ACT_CLEAR: lo_q <= '0;
      ACT_LOAD:  lo_q <= load_lo;
      ACT_STEP:  lo_q <= lo_q + LOW_W'(1);
      default:   lo_q <= lo_q;
    endcase
  end

  assign lo_at_max = &lo_q;

  // R5: lower stage frozen on hold
  a_r5_low_frozen: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_HOLD) |=> $stable(lo_q));

  // R1: lower stage advances on each enabled cycle
  a_r1_low_steps: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_STEP) |=> (lo_q == $past(lo_q) + LOW_W'(1)));
endmodule

// File: rtl/pscnt_high.sv
`timescale 1ns/1ps
module pscnt_high
  import pscnt_pkg::*;
#(
  parameter int HIGH_W = 30,
  parameter int LOW_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  cnt_act_e          act,
  input  logic              hi_step,
  input  logic [HIGH_W-1:0] load_hi,
  output logic [HIGH_W-1:0] hi_q,
  output logic              hi_full_q
);
  localparam logic [HIGH_W-1:0] HI_ONES = '1;
  localparam logic [HIGH_W-1:0] HI_PRE  = HI_ONES - HIGH_W'(1);
  localparam logic [LOW_W-1:0]  GAP_MAX = '1;

  // upper stage: changes at most once per prescaler period
  always_ff @(posedge clk) begin
    case (act)
      ACT_CLEAR: begin
        hi_q      <= '0;
        hi_full_q <= 1'b0;
      end
      ACT_LOAD: begin
        hi_q      <= load_hi;
        hi_full_q <= &load_hi;
      end
      default: begin
        if (hi_step) begin
          hi_q      <= hi_q + HIGH_W'(1);
          hi_full_q <= (hi_q == HI_PRE);
        end
      end
    endcase
  end

  // cycles since the last carry, saturating; reset to max after clear or load
  logic [LOW_W-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (act == ACT_CLEAR || act == ACT_LOAD) gap_q <= GAP_MAX;
    else if (hi_step)                         gap_q <= '0;
    else if (gap_q != GAP_MAX)                gap_q <= gap_q + LOW_W'(1);
  end

  // R4: upper stage holds without a carry
  a_r4_high_holds: assert property (@(posedge clk) disable iff (rst)
    (!hi_step && act != ACT_LOAD) |=> $stable(hi_q));

  // R4: upper stage steps by one on a carry
  a_r4_high_steps: assert property (@(posedge clk) disable iff (rst)
    hi_step |=> (hi_q == $past(hi_q) + HIGH_W'(1)));

  // R4: carries are a full prescaler period apart
  a_r4_step_spacing: assert property (@(posedge clk) disable iff (rst)
    hi_step |-> (gap_q == GAP_MAX));
endmodule

// File: rtl/pscnt_term.sv
`timescale 1ns/1ps
module pscnt_term
  import pscnt_pkg::*;
#(
  parameter int TOTAL_W = 32,
  parameter int LOW_W   = 2
) (
  input  logic               clk,
  input  cnt_act_e           act,
  input  logic [LOW_W-1:0]   lo_q,
  input  logic               hi_full,
  input  logic [TOTAL_W-1:0] load_val,
  output logic               term_q
);
  localparam logic [LOW_W-1:0] LO_PRE = LOW_W'((1 << LOW_W) - 2);

  // flag follows the count: set one step before all-ones is reached
  always_ff @(posedge clk) begin
    case (act)
      ACT_CLEAR: term_q <= 1'b0;
      ACT_LOAD:  term_q <= &load_val;
      ACT_STEP:  term_q <= hi_full && (lo_q == LO_PRE);
      default:   term_q <= term_q;
    endcase
  end
endmodule

// File: rtl/prescaled_counter.sv
`timescale 1ns/1ps
module prescaled_counter
  import pscnt_pkg::*;
#(
  parameter int TOTAL_W = 32,
  parameter int LOW_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cnt_en,
  input  logic               load_en,
  input  logic [TOTAL_W-1:0] load_val,
  output logic [TOTAL_W-1:0] count,
  output logic               term_cnt
);
  localparam int HIGH_W = TOTAL_W - LOW_W;

  cnt_act_e          act;
  logic              hi_step;
  logic              lo_at_max;
  logic              hi_full;
  logic [LOW_W-1:0]  lo_q;
  logic [HIGH_W-1:0] hi_q;

  pscnt_ctl u_ctl (
    .rst       (rst),
    .cnt_en    (cnt_en),
    .load_en   (load_en),
    .lo_at_max (lo_at_max),
    .act       (act),
    .hi_step   (hi_step)
  );

  pscnt_low #(.LOW_W(LOW_W)) u_low (
    .clk       (clk),
    .rst       (rst),
    .act       (act),
    .load_lo   (load_val[LOW_W-1:0]),
    .lo_q      (lo_q),
    .lo_at_max (lo_at_max)
  );

  pscnt_high #(.HIGH_W(HIGH_W), .LOW_W(LOW_W)) u_high (
    .clk       (clk),
    .rst       (rst),
    .act       (act),
    .hi_step   (hi_step),
    .load_hi   (load_val[TOTAL_W-1:LOW_W]),
    .hi_q      (hi_q),
    .hi_full_q (hi_full)
  );

  pscnt_term #(.TOTAL_W(TOTAL_W), .LOW_W(LOW_W)) u_term (
    .clk      (clk),
    .act      (act),
    .lo_q     (lo_q),
    .hi_full  (hi_full),
    .load_val (load_val),
    .term_q   (term_cnt)
  );

  assign count = {hi_q, lo_q};

  // R2: reset clears count and flag
  a_r2_reset_clears: assert property (@(posedge clk)
    rst |=> (count == '0) && !term_cnt);

  // R1: whole count behaves as a plain binary counter
  a_r1_binary_step: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !load_en) |=> (count == $past(count) + TOTAL_W'(1)));

  // R3: upper part moves after an enabled cycle at lower max
  a_r3_carry_moves_upper: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !load_en && (&count[LOW_W-1:0]))
      |=> (count[TOTAL_W-1:LOW_W] != $past(count[TOTAL_W-1:LOW_W])));

  // R5: held counter keeps count and flag
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !load_en) |=> ($stable(count) && $stable(term_cnt)));

  // R6: all-ones wraps to zero
  a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
    ((&count) && cnt_en && !load_en) |=> (count == '0));

  // R7: flag matches all-ones count
  a_r7_term_match: assert property (@(posedge clk) disable iff (rst)
    term_cnt == (&count));

  // R8: preset lands next edge
  a_r8_load: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (count == $past(load_val)));
endmodule

// File: tb/tb_prescaled_counter.sv
`timescale 1ns/1ps
module tb_prescaled_counter;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;
  // stimulus table: preset value, enabled cycles, expected final count
  localparam logic [31:0] V_START [NV] = '{32'h0000_0000, 32'h0000_00FD, 32'h3FFF_FFFE,
                                           32'h7FFF_FFFC, 32'hFFFF_FFFA, 32'hFFFF_FFFF,
                                           32'h5555_5556};
  localparam int          V_LEN   [NV] = '{20, 8, 6, 9, 10, 1, 7};
  localparam logic [31:0] V_END   [NV] = '{32'h0000_0014, 32'h0000_0105, 32'h4000_0004,
                                           32'h8000_0005, 32'h0000_0004, 32'h0000_0000,
                                           32'h5555_555D};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b0;
  logic        load_en = 1'b0;
  logic [31:0] load_val = '0;
  logic [31:0] count;
  logic        term_cnt;

  int total = 0;
  int bad = 0;

  prescaled_counter dut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .load_en(load_en),
    .load_val(load_val), .count(count), .term_cnt(term_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic preset(input logic [31:0] v);
    load_en = 1'b1; load_val = v; cnt_en = 1'b0;
    tick();
    load_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] prev;
    logic [31:0] refc;
    int carries;
    // R2: reset state
    tick(); tick();
    chk("R2 reset count", count, 32'h0);
    chk("R2 reset flag", {31'b0, term_cnt}, 32'h0);
    rst = 1'b0;

    // table walk: preset then count through a boundary
    for (int i = 0; i < NV; i++) begin
      preset(V_START[i]);
      chk("R8 preset", count, V_START[i]);
      chk("R7 flag after preset", {31'b0, term_cnt}, {31'b0, &V_START[i]});
      cnt_en = 1'b1;
      carries = 0;
      for (int c = 0; c < V_LEN[i]; c++) begin
        prev = count;
        tick();
        chk("R1 step", count, prev + 32'd1);
        if (prev[1:0] == 2'd3) begin
          carries++;
          chk("R4 upper steps", {2'b0, count[31:2]}, {2'b0, prev[31:2] + 30'd1});
        end else begin
          chk("R4 upper holds", {2'b0, count[31:2]}, {2'b0, prev[31:2]});
        end
        chk("R7 flag", {31'b0, term_cnt}, {31'b0, &(prev + 32'd1)});
      end
      cnt_en = 1'b0;
      chk("R1/R6 end of run", count, V_END[i]);
      chk("R3 carry count", carries, (((V_END[i] >> 2) - (V_START[i] >> 2)) & 32'h3FFF_FFFF));
    end

    // R5: freeze with lower stage at its top value
    preset(32'h0000_0007);
    for (int c = 0; c < 3; c++) tick();
    chk("R5 frozen at lower max", count, 32'h0000_0007);
    preset(32'h0000_0123);
    for (int c = 0; c < 5; c++) tick();
    chk("R5 frozen", count, 32'h0000_0123);

    // R3/R5: toggled enable against a reference
    preset(32'h0000_0002);
    refc = 32'h0000_0002;
    for (int c = 0; c < 12; c++) begin
      cnt_en = c[0];
      tick();
      if (c[0]) refc = refc + 32'd1;
      chk("R3 toggled enable", count, refc);
    end
    cnt_en = 1'b0;

    // R7: flag held while frozen at all ones, then R6 wrap clears it
    preset(32'hFFFF_FFFF);
    tick();
    chk("R7 flag held", {31'b0, term_cnt}, 32'h1);
    cnt_en = 1'b1;
    tick();
    cnt_en = 1'b0;
    chk("R6 wrap", count, 32'h0);
    chk("R7 flag cleared", {31'b0, term_cnt}, 32'h0);

    // R8: preset wins over enable
    load_en = 1'b1; cnt_en = 1'b1; load_val = 32'hABCD_0001;
    tick();
    load_en = 1'b0; cnt_en = 1'b0;
    chk("R8 preset priority", count, 32'hABCD_0001);

    // R2: reset wins over preset
    rst = 1'b1; load_en = 1'b1; load_val = 32'hFFFF_FFFF;
    tick();
    rst = 1'b0; load_en = 1'b0;
    chk("R2 reset priority", count, 32'h0);
    chk("R2 reset flag priority", {31'b0, term_cnt}, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule